// File: doc/BRIEF.md
# Two-Wire Register Slave with Status Readback

This block is a two-wire serial slave for bus clocks up to about 400 kHz. It sits in a fast system-clock domain. It samples the bus clock and data lines through synchronizers and finds bus events from their edges. It holds a bank of writable 8-bit control registers whose outputs drive the rest of the chip. It also answers reads with two status bytes.

A write transaction carries three kinds of byte in turn: the device address with a direction bit, a register pointer, and then any number of data bytes. Each data byte lands in the register the pointer names, and the pointer then steps to the next register. A read transaction ignores the pointer. It always returns status byte 1 first and status byte 2 second. One status bit records that the block has come out of reset with default settings. That bit stays set until a STOP ends a read.

Each stored byte raises a one-cycle strobe that carries the register index, so neighbouring logic can react when a given register is loaded. The data line is open-drain: `sda_oe` high means the block pulls SDA low.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is held and right after it: every control register holds its `REG_INIT` value, `sda_oe` is 0, `wr_stb` is 0, and the power-up flag is set.
- R2: The block answers only the 7-bit address `SLAVE_ADDR` (default 1100000), sent MSB first and followed by a direction bit where 0 means write and 1 means read. For any other address it does not ACK, and the transaction changes no register and raises no strobe.
- R3: After each accepted byte, the block pulls SDA low through the whole high phase of the ninth clock (ACK). When it refuses a byte, SDA stays released during that clock (NACK).
- R4: In a write, the first byte after the address is the register pointer and is always ACKed. Each data byte that follows arrives MSB first, is stored in the register the pointer names, and then moves the pointer up by one, until STOP.
- R5: A data byte whose pointer is `NUM_REGS` or above is NACKed and not stored. The block then ignores the bus until the next START or STOP.
- R6: Each stored byte raises `wr_stb` for exactly one cycle, with `wr_idx` set to the register index. `reg_q` changes in that same cycle and at no other time.
- R7: A read returns status byte 1, then status byte 2, then the two again in turn for as long as the master ACKs. Each byte goes out MSB first, and the register pointer has no effect on it. After a master NACK, the block releases SDA.
- R8: Status byte 1 is `stat1_i` with bit position `PWR_BIT` (default 2) replaced by the power-up flag. Status byte 2 is `stat2_i` unchanged. The flag is cleared only by a STOP that ends a read; a STOP after a write leaves it set.
- R9: A START in the middle of a byte drops the partial byte without storing it and restarts address matching.
- R10: The block changes `sda_oe` only while the synchronized SCL is low, except in the cycle right after a START or STOP.
- R11: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| stat1_i | input | 8 | Raw status byte 1; bit `PWR_BIT` is replaced by the power-up flag |
| stat2_i | input | 8 | Status byte 2 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_q | output | NUM_REGS*8 | All control registers; register k sits at bits [8k+7:8k] |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_idx | output | $clog2(NUM_REGS) | Index of the register just stored |

## Verification
The write path is driven from a table of pointer/data pairs. Some pairs are in range and some are past the end, so ACK versus NACK and stored versus dropped are told apart one byte at a time. Burst writes that start in the middle of the bank and near its top show that the pointer steps by one and stops storing exactly at the boundary. A foreign address, and a START cut into a half-sent byte, show that only a complete, addressed byte ever reaches a register. Reads made with different pointer values and with ACK or NACK endings show that the read order is fixed, that the two bytes alternate, and that only a STOP ending a read clears the power-up flag.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_WFALL,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } eng_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_t;

  // True when the upper seven bits of the first byte name this slave.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
    return b[7:1] == own;
  endfunction

  // True when a pointer falls inside the writable bank.
  function automatic logic ptr_ok(input logic [7:0] p, input int unsigned n);
    return {24'd0, p} < n;
  endfunction

  // Places the power-up flag into the raw status byte.
  function automatic logic [7:0] merge_status(input logic [7:0] raw,
                                              input logic flag,
                                              input int unsigned pos);
    logic [7:0] r;
    r = raw;
    r[pos] = flag;
    return r;
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  // Idle bus is high, so the chains reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1100000,
  parameter int         NUM_REGS   = 8,
  localparam int        IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       stat_byte1,
  input  logic [7:0]       stat_byte2,
  output logic             sda_oe,
  output logic             wr_req,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             rd_stop
);

  eng_state_t state;
  rx_kind_t   kind;
  logic [2:0] bitcnt;
  logic [7:0] sr;
  logic [7:0] txsr;
  logic [7:0] ptr;
  logic       ack_pend;
  logic       rd_mode;
  logic       rd_sel;
  logic       mack;
  logic [7:0] rx_next;
  logic       last_bit;

  assign rx_next  = {sr[6:0], sda_s};
  assign last_bit = (bitcnt == 3'd7);

  // Open-drain drive: low during ACK, or while sending a zero bit.
  assign sda_oe = (state == ST_ACK) | ((state == ST_TX) & ~txsr[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      sr       <= '0;
      txsr     <= '0;
      ptr      <= '0;
      ack_pend <= 1'b0;
      rd_mode  <= 1'b0;
      rd_sel   <= 1'b0;
      mack     <= 1'b0;
      wr_req   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      rd_stop  <= 1'b0;
    end else begin
      wr_req  <= 1'b0;
      rd_stop <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        kind    <= K_ADDR;
        bitcnt  <= '0;
        rd_mode <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        rd_stop <= rd_mode;
        rd_mode <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              sr     <= rx_next;
              bitcnt <= bitcnt + 3'd1;
              if (last_bit) begin
                state <= ST_WFALL;
                unique case (kind)
                  K_ADDR: begin
                    ack_pend <= addr_hit(rx_next, SLAVE_ADDR);
                    rd_mode  <= addr_hit(rx_next, SLAVE_ADDR) & rx_next[0];
                  end
                  K_PTR: begin
                    ptr      <= rx_next;
                    ack_pend <= 1'b1;
                  end
                  default: begin
                    if (ptr_ok(ptr, NUM_REGS)) begin
                      wr_req   <= 1'b1;
                      wr_idx   <= ptr[IDX_W-1:0];
                      wr_data  <= rx_next;
                      ptr      <= ptr + 8'd1;
                      ack_pend <= 1'b1;
                    end else begin
                      ack_pend <= 1'b0;
                    end
                  end
                endcase
              end
            end
          end
          ST_WFALL: begin
            if (scl_fall) state <= ack_pend ? ST_ACK : ST_SKIP;
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                state  <= ST_TX;
                txsr   <= stat_byte1;
                rd_sel <= 1'b1;
              end else begin
                state <= ST_RX;
                kind  <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (last_bit) begin
                state  <= ST_TXACK;
                bitcnt <= '0;
              end else begin
                txsr   <= {txsr[6:0], 1'b1};
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                state  <= ST_TX;
                txsr   <= rd_sel ? stat_byte2 : stat_byte1;
                rd_sel <= ~rd_sel;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cs_regbank.sv
`timescale 1ns/1ps
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int                    NUM_REGS = 8,
  parameter int                    PWR_BIT  = 2,
  parameter logic [NUM_REGS*8-1:0] REG_INIT = '0,
  localparam int                   IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [IDX_W-1:0]      wr_idx_in,
  input  logic [7:0]            wr_data,
  input  logic                  rd_stop,
  input  logic [7:0]            stat1_raw,
  input  logic [7:0]            stat2_raw,
  output logic [NUM_REGS*8-1:0] reg_flat,
  output logic                  wr_stb,
  output logic [IDX_W-1:0]      wr_idx,
  output logic                  pwr_flag,
  output logic [7:0]            stat_byte1,
  output logic [7:0]            stat_byte2
);

  logic [7:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= REG_INIT[k*8 +: 8];
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      pwr_flag <= 1'b1;
    end else begin
      wr_stb <= wr_req;
      if (wr_req) begin
        wr_idx         <= wr_idx_in;
        regs_q[wr_idx_in] <= wr_data;
      end
      if (rd_stop) pwr_flag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign reg_flat[g*8 +: 8] = regs_q[g];
  end

  assign stat_byte1 = merge_status(stat1_raw, pwr_flag, PWR_BIT);
  assign stat_byte2 = stat2_raw;

endmodule

// File: rtl/i2c_reg_slave.sv
`timescale 1ns/1ps
module i2c_reg_slave #(
  parameter logic [6:0]            SLAVE_ADDR  = 7'b1100000,
  parameter int                    NUM_REGS    = 8,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    PWR_BIT     = 2,
  parameter logic [NUM_REGS*8-1:0] REG_INIT    = '0,
  localparam int                   IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [7:0]            stat1_i,
  input  logic [7:0]            stat2_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_q,
  output logic                  wr_stb,
  output logic [IDX_W-1:0]      wr_idx
);

  // Internal events, named for the checker.
  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_req;
  logic [IDX_W-1:0] req_idx;
  logic [7:0]       req_data;
  logic             rd_stop;
  logic             pwr_flag;
  logic [7:0]       stat_byte1;
  logic [7:0]       stat_byte2;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .stat_byte1 (stat_byte1),
    .stat_byte2 (stat_byte2),
    .sda_oe     (sda_oe),
    .wr_req     (wr_req),
    .wr_idx     (req_idx),
    .wr_data    (req_data),
    .rd_stop    (rd_stop)
  );

  i2cs_regbank #(.NUM_REGS(NUM_REGS), .PWR_BIT(PWR_BIT), .REG_INIT(REG_INIT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .wr_idx_in  (req_idx),
    .wr_data    (req_data),
    .rd_stop    (rd_stop),
    .stat1_raw  (stat1_i),
    .stat2_raw  (stat2_i),
    .reg_flat   (reg_q),
    .wr_stb     (wr_stb),
    .wr_idx     (wr_idx),
    .pwr_flag   (pwr_flag),
    .stat_byte1 (stat_byte1),
    .stat_byte2 (stat_byte2)
  );

endmodule

// File: rtl/i2cs_checker.sv
`timescale 1ns/1ps
module i2cs_checker #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic                  wr_stb,
  input logic [NUM_REGS*8-1:0] reg_q,
  input logic                  pwr_flag
);

  a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r6_regs_move_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q != $past(reg_q)) |-> wr_stb);

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(start_det) || $past(stop_det)));

  a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r8_flag_clears_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_flag) |-> $past(stop_det, 2));

  a_r8_flag_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pwr_flag));

endmodule

bind i2c_reg_slave i2cs_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .wr_stb    (wr_stb),
  .reg_q     (reg_q),
  .pwr_flag  (pwr_flag)
);

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
module test_i2c_reg_slave;

  localparam int NREG = 8;
  localparam int Q    = 8;
  localparam logic [7:0] AW = 8'hC0;  // 1100000 + write
  localparam logic [7:0] AR = 8'hC1;  // 1100000 + read
  localparam logic [7:0] ST1 = 8'hB3; // bit 2 clear in the raw value
  localparam logic [7:0] ST2 = 8'h6E;

  // {pointer, data, expected ack}
  localparam int NVEC = 7;
  localparam logic [16:0] WTAB [NVEC] = '{
    {8'h00, 8'h3C, 1'b1},
    {8'h07, 8'hA5, 1'b1},
    {8'h03, 8'h5A, 1'b1},
    {8'h08, 8'h77, 1'b0},
    {8'hFF, 8'h11, 1'b0},
    {8'h00, 8'hC3, 1'b1},
    {8'h05, 8'h0F, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] reg_q;
  logic wr_stb;
  logic [2:0] wr_idx;
  logic [NREG*8-1:0] exp_q = '0;
  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  logic [2:0] last_idx = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .stat1_i (ST1),
    .stat2_i (ST2),
    .sda_oe  (sda_oe),
    .reg_q   (reg_q),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt++;
      last_idx = wr_idx;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      d[i] = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    bit_out(~mack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    int s0;

    tick(5);
    // R1: reset state
    check("R1 sda released in reset", {63'd0, sda_oe}, 64'd0);
    rst_n = 1'b1;
    tick(3);
    check("R1 regs at init", reg_q, exp_q);
    check("R1 no strobe", {63'd0, wr_stb}, 64'd0);
    check("R1 sda released", {63'd0, sda_oe}, 64'd0);

    // R2 R3 R4 R5 R6: table of single writes
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] p;
      logic [7:0] d;
      logic       ea;
      {p, d, ea} = WTAB[v];
      s0 = stb_cnt;
      bus_start();
      send_byte(AW, ack);
      check("R2 own write address acked", {63'd0, ack}, 64'd1);
      send_byte(p, ack);
      check("R4 pointer acked", {63'd0, ack}, 64'd1);
      send_byte(d, ack);
      check("R3 R5 data ack/nack", {63'd0, ack}, {63'd0, ea});
      bus_stop();
      if (p < NREG) exp_q[p*8 +: 8] = d;
      check("R4 R5 register contents", reg_q, exp_q);
      check("R6 strobe count", 64'(stb_cnt - s0), ea ? 64'd1 : 64'd0);
      if (ea) check("R6 strobe index", {61'd0, last_idx}, {61'd0, p[2:0]});
      check("R11 released after stop", {63'd0, sda_oe}, 64'd0);
    end

    // R4 R6: burst write with auto-increment
    s0 = stb_cnt;
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h02, ack);
    send_byte(8'h11, ack); check("R4 burst byte 0", {63'd0, ack}, 64'd1);
    send_byte(8'h22, ack); check("R4 burst byte 1", {63'd0, ack}, 64'd1);
    send_byte(8'h33, ack); check("R4 burst byte 2", {63'd0, ack}, 64'd1);
    bus_stop();
    exp_q[2*8 +: 8] = 8'h11;
    exp_q[3*8 +: 8] = 8'h22;
    exp_q[4*8 +: 8] = 8'h33;
    check("R4 burst contents", reg_q, exp_q);
    check("R6 burst strobes", 64'(stb_cnt - s0), 64'd3);
    check("R6 burst last index", {61'd0, last_idx}, 64'd4);

    // R5: burst running past the top of the bank
    s0 = stb_cnt;
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h06, ack);
    send_byte(8'h44, ack); check("R5 reg6 acked", {63'd0, ack}, 64'd1);
    send_byte(8'h55, ack); check("R5 reg7 acked", {63'd0, ack}, 64'd1);
    send_byte(8'h66, ack); check("R5 past end nacked", {63'd0, ack}, 64'd0);
    bus_stop();
    exp_q[6*8 +: 8] = 8'h44;
    exp_q[7*8 +: 8] = 8'h55;
    check("R5 boundary contents", reg_q, exp_q);
    check("R5 boundary strobes", 64'(stb_cnt - s0), 64'd2);

    // R2: foreign address
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hC2, ack);
    check("R2 foreign address nacked", {63'd0, ack}, 64'd0);
    send_byte(8'h01, ack);
    send_byte(8'hEE, ack);
    bus_stop();
    check("R2 foreign address leaves regs", reg_q, exp_q);
    check("R2 foreign address no strobe", 64'(stb_cnt - s0), 64'd0);

    // R9: START cut into a data byte
    s0 = stb_cnt;
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h04, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start();
    send_byte(AW, ack);
    check("R9 address matched after restart", {63'd0, ack}, 64'd1);
    send_byte(8'h05, ack);
    send_byte(8'h99, ack);
    bus_stop();
    exp_q[5*8 +: 8] = 8'h99;
    check("R9 partial byte dropped", reg_q, exp_q);
    check("R9 single strobe", 64'(stb_cnt - s0), 64'd1);

    // R7 R8: read after pointer set, flag still set after write stops
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h06, ack);
    bus_start();
    send_byte(AR, ack);
    check("R2 own read address acked", {63'd0, ack}, 64'd1);
    read_byte(1'b1, rd);
    check("R7 R8 first byte is status 1 with flag", {56'd0, rd}, {56'd0, ST1 | 8'h04});
    read_byte(1'b1, rd);
    check("R7 second byte is status 2", {56'd0, rd}, {56'd0, ST2});
    read_byte(1'b0, rd);
    check("R7 third byte wraps to status 1", {56'd0, rd}, {56'd0, ST1 | 8'h04});
    tick(Q);
    check("R7 released after master nack", {63'd0, sda_oe}, 64'd0);
    bus_stop();

    // R8: flag cleared by the read-ending STOP
    bus_start();
    send_byte(AR, ack);
    read_byte(1'b1, rd);
    check("R8 flag cleared after read stop", {56'd0, rd}, {56'd0, ST1 & 8'hFB});
    read_byte(1'b0, rd);
    check("R7 status 2 on second read", {56'd0, rd}, {56'd0, ST2});
    bus_stop();
    check("R11 idle released", {63'd0, sda_oe}, 64'd0);
    check("R7 read leaves regs", reg_q, exp_q);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule